// File: doc/BRIEF.md
# ID-qualified transfer filter for memory performance counters

This block sits between a memory controller's transfer strobes and three general event counters of a performance counter bank. Each counter is assigned an event code by the bank. For two codes the block decides, transfer by transfer, whether a data transfer counts: code 0x41 looks at read transfers and code 0x42 at write transfers. A transfer qualifies when its transaction ID agrees with a compare value on the bits that a mask selects. In the per-counter build it must also come from a chosen port and channel. For every other code, the counter's raw event strobe passes straight through.

Each counter has a filter word and a selection word. The filter word holds the compare ID in its low half and the mask in its high half. The mask is kept exactly as software writes it, which is bit-inverted. The selection word names the read port and channel and the write port and channel. Both channel bits are kept inverted. A build parameter switches to a single shared filter word that serves all counters and skips the port and channel test. Next to the per-transfer increment, every counter keeps a byte total for its qualifying transfers. Software reads that total through a separate window and zeroes it by writing to that window.

The increment output is registered, so a transfer presented on one clock edge shows on `cnt_inc_o` just after that edge. Register writes take effect at the edge that samples them. Reads are combinational from the address.

Top module: `xact_id_filter`

## Requirements
- R1: After reset, `cnt_inc_o` is all zeros and every readable register (0x30, 0x34, 0x38, 0x3C, 0x50, 0x54, 0x60, 0x64, 0x70, 0x74) returns 0.
- R2: For a counter whose event code is neither 0x41 nor 0x42, its bit of `cnt_inc_o` equals that counter's bit of `raw_evt_i` from the previous edge.
- R3: For a counter with code 0x41, its bit of `cnt_inc_o` is 1 one edge after a qualifying read transfer and 0 otherwise. Write transfers and `raw_evt_i` have no effect on it.
- R4: For a counter with code 0x42, its bit of `cnt_inc_o` is 1 one edge after a qualifying write transfer and 0 otherwise. Read transfers and `raw_evt_i` have no effect on it.
- R5: In a filter word, bits 15:0 hold the compare ID and bits 31:16 hold the mask in inverted form. An ID bit must equal the compare bit where the stored mask bit is 0. It is ignored where the stored mask bit is 1.
- R6: Counter n (1 to 3) has its selection word at 0x50+16*(n-1) and its filter word at 0x54+16*(n-1). The shared filter word is at 0x30. A filter word reads back exactly as written. A selection word keeps only bits 11:8 and 3:0, and its other bits read 0.
- R7: In the per-counter build, a read qualifies only if its port equals selection bits 2:0 and its channel input equals the inverse of bit 3. A write qualifies only if its port equals bits 10:8 and its channel input equals the inverse of bit 11.
- R8: With `PER_COUNTER`=0, every counter uses the word at 0x30 and port and channel are ignored. With `PER_COUNTER`=1, the word at 0x30 does not affect qualification.
- R9: A read at 0x30+4*n returns counter n's byte total. Each qualifying transfer adds beats*2^size, and the total wraps modulo 2^`BYTE_W`. A counter with any other code adds nothing.
- R10: Any write to 0x30+4*n zeroes counter n's byte total, whatever the write data. This clear takes precedence over an addition in the same cycle.
- R11: A read and a write transfer in the same cycle are both evaluated, so a 0x41 counter and a 0x42 counter can both increment on one edge.
- R12: Counters are configured and accumulate independently. Clearing or reconfiguring one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| evt_code_i | input | NCNT*8 | Event code per counter, counter 1 in the low byte |
| raw_evt_i | input | NCNT | Unfiltered event strobe per counter |
| rd_valid_i | input | 1 | Read transfer present |
| rd_id_i | input | 16 | Read transaction ID |
| rd_port_i | input | 3 | Read source port |
| rd_chan_i | input | 1 | Read channel |
| rd_size_i | input | 3 | Read beat size, log2 bytes |
| rd_beats_i | input | 9 | Read beat count |
| wr_valid_i | input | 1 | Write transfer present |
| wr_id_i | input | 16 | Write transaction ID |
| wr_port_i | input | 3 | Write source port |
| wr_chan_i | input | 1 | Write channel |
| wr_size_i | input | 3 | Write beat size, log2 bytes |
| wr_beats_i | input | 9 | Write beat count |
| cnt_inc_o | output | NCNT | Registered count increment per counter |

## Verification
The main instance is built with three counters, the per-counter filter and a 12-bit byte total. With that width, a few large transfers are enough to carry the accumulator past 4096 and show the wrap. A second instance shares the same stimulus and is built with `PER_COUNTER`=0. On a transfer from a port that the per-counter instance rejects, only the shared-word instance counts it, which shows the two builds apart.

// File: rtl/xif_pkg.sv
package xif_pkg;
  localparam int ID_W   = 16;
  localparam int PORT_W = 3;
  localparam int SIZE_W = 3;
  localparam int BEAT_W = 9;
  localparam int EVT_W  = 8;
  localparam int AMT_W  = BEAT_W + (1 << SIZE_W) - 1;

  localparam logic [EVT_W-1:0] EVT_FILT_RD = 8'h41;
  localparam logic [EVT_W-1:0] EVT_FILT_WR = 8'h42;

  localparam int A_SHARED   = 'h30;
  localparam int A_BYTE1    = 'h34;
  localparam int A_SEL1     = 'h50;
  localparam int A_FILT1    = 'h54;
  localparam int BYTE_STEP  = 4;
  localparam int LANE_STEP  = 16;
  localparam logic [31:0] SEL_KEEP = 32'h0000_0F0F;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PORT_W-1:0] port;
    logic              chan;
    logic [SIZE_W-1:0] size;
    logic [BEAT_W-1:0] beats;
  } xfer_t;

  // Stored mask is inverted: a stored 0 means "compare this bit".
  function automatic logic id_hit(input logic [ID_W-1:0] id, input logic [31:0] word);
    logic [ID_W-1:0] care;
    care = ~word[31:16];
    return ((id ^ word[ID_W-1:0]) & care) == '0;
  endfunction

  function automatic logic [AMT_W-1:0] xfer_bytes(input logic [BEAT_W-1:0] beats,
                                                  input logic [SIZE_W-1:0] size);
    return AMT_W'(beats) << size;
  endfunction

  function automatic int sel_addr(input int idx);
    return A_SEL1 + LANE_STEP * idx;
  endfunction

  function automatic int filt_addr(input int idx);
    return A_FILT1 + LANE_STEP * idx;
  endfunction

  function automatic int byte_addr(input int idx);
    return A_BYTE1 + BYTE_STEP * idx;
  endfunction
endpackage

// File: rtl/xif_match.sv
module xif_match
  import xif_pkg::*;
#(
  parameter bit USE_SEL = 1'b1
) (
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              chan_i,
  input  logic [31:0]       word_i,
  input  logic [PORT_W-1:0] sel_port_i,
  input  logic              sel_chan_inv_i,
  output logic              hit_o
);
  logic id_ok;
  logic path_ok;

  assign id_ok   = id_hit(id_i, word_i);
  assign path_ok = USE_SEL ? ((port_i == sel_port_i) && (chan_i == ~sel_chan_inv_i)) : 1'b1;
  assign hit_o   = valid_i && id_ok && path_ok;
endmodule

// File: rtl/xif_lane.sv
module xif_lane
  import xif_pkg::*;
#(
  parameter int IDX         = 0,
  parameter int ADDR_W      = 8,
  parameter int BYTE_W      = 32,
  parameter bit PER_COUNTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [31:0]       shared_word_i,
  input  logic [EVT_W-1:0]  evt_code_i,
  input  logic              raw_evt_i,
  input  xfer_t             rd_i,
  input  xfer_t             wr_i,
  output logic              inc_o,
  output logic [31:0]       sel_o,
  output logic [31:0]       filt_o,
  output logic [BYTE_W-1:0] bytes_o
);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(sel_addr(IDX));
  localparam logic [ADDR_W-1:0] FILT_A = ADDR_W'(filt_addr(IDX));
  localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(byte_addr(IDX));

  logic [31:0]       sel_q, filt_q, word;
  logic              rd_hit, wr_hit, is_rd, is_wr, filt_on, lane_hit, inc_d, byte_clr;
  logic [BYTE_W-1:0] add_amt, bytes_q;

  assign word = PER_COUNTER ? filt_q : shared_word_i;

  xif_match #(.USE_SEL(PER_COUNTER)) u_rd_match (
    .valid_i(rd_i.valid), .id_i(rd_i.id), .port_i(rd_i.port), .chan_i(rd_i.chan),
    .word_i(word), .sel_port_i(sel_q[2:0]), .sel_chan_inv_i(sel_q[3]), .hit_o(rd_hit)
  );

  xif_match #(.USE_SEL(PER_COUNTER)) u_wr_match (
    .valid_i(wr_i.valid), .id_i(wr_i.id), .port_i(wr_i.port), .chan_i(wr_i.chan),
    .word_i(word), .sel_port_i(sel_q[10:8]), .sel_chan_inv_i(sel_q[11]), .hit_o(wr_hit)
  );

  assign is_rd    = (evt_code_i == EVT_FILT_RD);
  assign is_wr    = (evt_code_i == EVT_FILT_WR);
  assign filt_on  = is_rd || is_wr;
  assign lane_hit = (is_rd && rd_hit) || (is_wr && wr_hit);
  assign inc_d    = filt_on ? lane_hit : raw_evt_i;
  assign add_amt  = is_rd ? BYTE_W'(xfer_bytes(rd_i.beats, rd_i.size))
                          : BYTE_W'(xfer_bytes(wr_i.beats, wr_i.size));
  assign byte_clr = reg_we_i && (reg_addr_i == BYTE_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      filt_q  <= '0;
      inc_q_r <= 1'b0;
      bytes_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == SEL_A)  sel_q  <= reg_wdata_i & SEL_KEEP;
      if (reg_we_i && reg_addr_i == FILT_A) filt_q <= reg_wdata_i;
      inc_q_r <= inc_d;
      if (byte_clr)      bytes_q <= '0;
      else if (lane_hit) bytes_q <= bytes_q + add_amt;
    end
  end

  logic inc_q_r;
  assign inc_o   = inc_q_r;
  assign sel_o   = sel_q;
  assign filt_o  = filt_q;
  assign bytes_o = bytes_q;

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_on |=> (inc_o == $past(raw_evt_i)));
  // R3
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> (inc_o == $past(rd_hit)));
  // R4
  wr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> (inc_o == $past(wr_hit)));
  // R7
  port_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && PER_COUNTER) |-> (rd_i.port == sel_q[2:0]));
  // R10
  byte_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_clr |=> (bytes_o == '0));
  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_clr && !lane_hit) |=> $stable(bytes_o));
endmodule

// File: rtl/xact_id_filter.sv
module xact_id_filter
  import xif_pkg::*;
#(
  parameter int NCNT        = 3,
  parameter int ADDR_W      = 8,
  parameter int BYTE_W      = 32,
  parameter bit PER_COUNTER = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic [NCNT*EVT_W-1:0] evt_code_i,
  input  logic [NCNT-1:0]       raw_evt_i,
  input  logic                  rd_valid_i,
  input  logic [ID_W-1:0]       rd_id_i,
  input  logic [PORT_W-1:0]     rd_port_i,
  input  logic                  rd_chan_i,
  input  logic [SIZE_W-1:0]     rd_size_i,
  input  logic [BEAT_W-1:0]     rd_beats_i,
  input  logic                  wr_valid_i,
  input  logic [ID_W-1:0]       wr_id_i,
  input  logic [PORT_W-1:0]     wr_port_i,
  input  logic                  wr_chan_i,
  input  logic [SIZE_W-1:0]     wr_size_i,
  input  logic [BEAT_W-1:0]     wr_beats_i,
  output logic [NCNT-1:0]       cnt_inc_o
);
  localparam logic [ADDR_W-1:0] SHARED_A = ADDR_W'(A_SHARED);

  xfer_t             rd_x, wr_x;
  logic [31:0]       shared_q;
  logic [31:0]       sel_a  [NCNT];
  logic [31:0]       filt_a [NCNT];
  logic [BYTE_W-1:0] byte_a [NCNT];

  assign rd_x = '{valid: rd_valid_i, id: rd_id_i, port: rd_port_i, chan: rd_chan_i,
                  size: rd_size_i, beats: rd_beats_i};
  assign wr_x = '{valid: wr_valid_i, id: wr_id_i, port: wr_port_i, chan: wr_chan_i,
                  size: wr_size_i, beats: wr_beats_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                shared_q <= '0;
    else if (reg_we_i && reg_addr_i == SHARED_A) shared_q <= reg_wdata_i;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_lane
    xif_lane #(
      .IDX(g), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .PER_COUNTER(PER_COUNTER)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .shared_word_i(shared_q),
      .evt_code_i(evt_code_i[g*EVT_W +: EVT_W]), .raw_evt_i(raw_evt_i[g]),
      .rd_i(rd_x), .wr_i(wr_x),
      .inc_o(cnt_inc_o[g]), .sel_o(sel_a[g]), .filt_o(filt_a[g]), .bytes_o(byte_a[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == SHARED_A) reg_rdata_o = shared_q;
    for (int i = 0; i < NCNT; i++) begin
      if (reg_addr_i == ADDR_W'(sel_addr(i)))  reg_rdata_o = sel_a[i];
      if (reg_addr_i == ADDR_W'(filt_addr(i))) reg_rdata_o = filt_a[i];
      if (reg_addr_i == ADDR_W'(byte_addr(i))) reg_rdata_o = 32'(byte_a[i]);
    end
  end
endmodule

// File: tb/xact_id_filter_tb.sv
module xact_id_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT = 3;
  localparam int BYTE_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_sh;
  logic [23:0] evt_code = '0;
  logic [2:0] raw_evt = '0;
  logic rd_valid = 0, rd_chan = 0, wr_valid = 0, wr_chan = 0;
  logic [15:0] rd_id = '0, wr_id = '0;
  logic [2:0] rd_port = '0, rd_size = '0, wr_port = '0, wr_size = '0;
  logic [8:0] rd_beats = '0, wr_beats = '0;
  logic [2:0] cnt_inc, cnt_inc_sh;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic [2:0] mon_e;
  string mon_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  xact_id_filter #(.NCNT(NCNT), .ADDR_W(8), .BYTE_W(BYTE_W), .PER_COUNTER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .evt_code_i(evt_code), .raw_evt_i(raw_evt),
    .rd_valid_i(rd_valid), .rd_id_i(rd_id), .rd_port_i(rd_port), .rd_chan_i(rd_chan),
    .rd_size_i(rd_size), .rd_beats_i(rd_beats),
    .wr_valid_i(wr_valid), .wr_id_i(wr_id), .wr_port_i(wr_port), .wr_chan_i(wr_chan),
    .wr_size_i(wr_size), .wr_beats_i(wr_beats), .cnt_inc_o(cnt_inc));

  xact_id_filter #(.NCNT(NCNT), .ADDR_W(8), .BYTE_W(BYTE_W), .PER_COUNTER(1'b0)) u_dut_sh (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata_sh), .evt_code_i(evt_code), .raw_evt_i(raw_evt),
    .rd_valid_i(rd_valid), .rd_id_i(rd_id), .rd_port_i(rd_port), .rd_chan_i(rd_chan),
    .rd_size_i(rd_size), .rd_beats_i(rd_beats),
    .wr_valid_i(wr_valid), .wr_id_i(wr_id), .wr_port_i(wr_port), .wr_chan_i(wr_chan),
    .wr_size_i(wr_size), .wr_beats_i(wr_beats), .cnt_inc_o(cnt_inc_sh));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compares each registered increment against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check(cnt_inc === mon_e, mon_t, "cnt_inc", 32'(cnt_inc), 32'(mon_e));
    end
  end

  // Driver: inputs already set at a falling edge; push expectation, clock once, idle.
  task automatic step(input logic [2:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    wr_valid = 1'b0;
    raw_evt = '0;
  endtask

  task automatic rd_xfer(input logic [15:0] id, input logic [2:0] port, input logic ch,
                         input logic [2:0] sz, input logic [8:0] bt);
    rd_valid = 1'b1; rd_id = id; rd_port = port; rd_chan = ch; rd_size = sz; rd_beats = bt;
  endtask

  task automatic wr_xfer(input logic [15:0] id, input logic [2:0] port, input logic ch,
                         input logic [2:0] sz, input logic [8:0] bt);
    wr_valid = 1'b1; wr_id = id; wr_port = port; wr_chan = ch; wr_size = sz; wr_beats = bt;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(rdata === exp, tag, $sformatf("read 0x%02h", a), rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(cnt_inc === 3'b000, "R1", "cnt_inc after reset", 32'(cnt_inc), 0);
    rreg(8'h30, 0, "R1"); rreg(8'h34, 0, "R1"); rreg(8'h38, 0, "R1"); rreg(8'h3C, 0, "R1");
    rreg(8'h50, 0, "R1"); rreg(8'h54, 0, "R1"); rreg(8'h60, 0, "R1"); rreg(8'h74, 0, "R1");

    // R2: unfiltered codes pass the raw strobes
    evt_code = {8'h04, 8'h04, 8'h04};
    raw_evt = 3'b101; step(3'b101, "R2");
    raw_evt = 3'b010; step(3'b010, "R2");

    // R6: configuration and readback
    wreg(8'h54, 32'h00FF_1234);       // stored mask 00FF -> compare id[15:8]
    wreg(8'h50, 32'hFFFF_F50A);       // rd port 2, rd ch bit 1, wr port 5, wr ch bit 0
    wreg(8'h64, 32'h0000_BEEF);       // exact compare
    wreg(8'h60, 32'h0000_0500);       // wr port 5, wr ch bit 0
    rreg(8'h54, 32'h00FF_1234, "R6");
    rreg(8'h50, 32'h0000_050A, "R6");
    rreg(8'h64, 32'h0000_BEEF, "R6");
    rreg(8'h60, 32'h0000_0500, "R6");

    evt_code = {8'h08, 8'h42, 8'h41};
    // R3 R5: read hit on upper byte, raw passes on counter 3
    rd_xfer(16'h12AB, 3'd2, 1'b0, 3'd2, 9'd4); raw_evt = 3'b111; step(3'b101, "R3");
    // R5: differs in a compared bit
    rd_xfer(16'h13AB, 3'd2, 1'b0, 3'd2, 9'd4); step(3'b000, "R5");
    // R7: wrong port
    rd_xfer(16'h12AB, 3'd3, 1'b0, 3'd2, 9'd4); step(3'b000, "R7");
    // R7: channel equals stored bit, not its inverse
    rd_xfer(16'h12AB, 3'd2, 1'b1, 3'd2, 9'd4); step(3'b000, "R7");
    // R11 R4: read and write in one cycle
    wr_xfer(16'hBEEF, 3'd5, 1'b1, 3'd3, 9'd2);
    rd_xfer(16'h12FF, 3'd2, 1'b0, 3'd0, 9'd3); step(3'b011, "R11");
    // R4 R5: exact mask rejects one-bit difference
    wr_xfer(16'hBEEE, 3'd5, 1'b1, 3'd3, 9'd2); step(3'b000, "R4");
    // R3 R4: raw strobes ignored on filtered counters
    raw_evt = 3'b111; step(3'b100, "R3");

    // R9: byte totals
    rreg(8'h34, 32'd19, "R9");
    rreg(8'h38, 32'd16, "R9");
    rreg(8'h3C, 32'd0, "R9");

    // R10 R12: clear counter 1 only
    wreg(8'h34, 32'h0000_DEAD);
    rreg(8'h34, 32'd0, "R10");
    rreg(8'h38, 32'd16, "R12");

    // R9: wrap modulo 2^BYTE_W
    rd_xfer(16'h12AB, 3'd2, 1'b0, 3'd4, 9'd255); step(3'b001, "R9");
    rreg(8'h34, 32'h0000_0FF0, "R9");
    rd_xfer(16'h12AB, 3'd2, 1'b0, 3'd3, 9'd4); step(3'b001, "R9");
    rreg(8'h34, 32'h0000_0010, "R9");

    // R8: shared word, port and channel ignored only in the shared build
    wreg(8'h30, 32'hFFF0_0005);
    rreg(8'h30, 32'hFFF0_0005, "R8");
    rd_xfer(16'h7775, 3'd6, 1'b1, 3'd0, 9'd1); step(3'b000, "R8");
    check(cnt_inc_sh === 3'b001, "R8", "shared cnt_inc", 32'(cnt_inc_sh), 32'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule